// File: doc/BRIEF.md
# Bit-Serial Accumulator Execution Unit

This block executes single-address orders for a small serial computer. It holds two 35-bit registers, an accumulator and a multiplier register. Arithmetic is fixed-point two's complement and runs one digit per clock with a single carry flip-flop. An order is a 17-bit word carrying a function code, a 10-bit address and a length flag. Memory operands enter and leave on one-bit serial lines, least significant digit first. An external sequencer owns the store and fetches the orders.

Once an order is accepted, the unit drives the address and the read or write enable for each digit. After the last digit it pulses `done`. A taken conditional jump raises `jumpReq` in the same cycle as `done`, with `jumpAddr` set to the target. A stop order or an unknown function code parks the unit in a halted state, which only reset clears. The parallel views `accOut` and `multOut` let the sequencer or a monitor observe the two registers.

Top module: `serial_acc_unit`

## Requirements
- R1: Order word fields: bits [16:12] function, bit 11 ignored, bits [10:1] address, bit 0 length (1 = long 35-bit operand, 0 = short 17-bit operand). Function codes: 0 no-op, 1 add, 2 subtract, 3 load multiplier, 4 collate, 5 store-and-clear, 6 store, 7 shift right, 8 shift left, 9 jump if negative, 10 jump if non-negative, 11 stop.
- R2: Add and subtract change the accumulator by plus or minus the operand, modulo 2^35. A short operand is the 17 digits it delivers, sign-extended from digit 16.
- R3: Load multiplier sets the multiplier register to the (extended) operand. No other order changes the multiplier register.
- R4: Store-and-clear writes the accumulator, LSB first, on memWrBit for 17 (short) or 35 (long) digits, then leaves the accumulator zero.
- R5: Store writes the accumulator in the same way as R4 and leaves the accumulator unchanged.
- R6: Collate adds (operand AND multiplier register) to the accumulator, modulo 2^35.
- R7: The shift count is address bits [5:0]. Shift right is arithmetic (sign fill). Shift left fills with zeros. A count of 0 leaves the accumulator unchanged.
- R8: Jump if negative is taken when accumulator bit 34 is 1. Jump if non-negative is taken when that bit is 0. A taken jump pulses jumpReq together with done, with jumpAddr equal to the order's address. Neither jump changes the accumulator.
- R9: A no-op changes neither register and completes with done in the cycle after acceptance.
- R10: Stop sets halted. While halted, orderReady stays low, orders are ignored and both registers keep their values until reset.
- R11: A function code above 11 sets illegal and halted, and leaves the registers unchanged.
- R12: An order is accepted when orderValid and orderReady are both high. Digit cycles start in the next cycle. Memory and jump orders take 35 digit cycles. A shift takes max(count,1) cycles. memRdEn, or memWrEn, is high for the operand-length digits starting with the first digit, and memAddr holds the address during those digits. done pulses in the cycle after the last digit.
- R13: After reset both registers are zero, orderReady is 1, and halted, illegal, done and jumpReq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit clock |
| rstN | input | 1 | Active-low synchronous reset |
| orderValid | input | 1 | Order word presented |
| orderWord | input | 17 | Function, spare, address, length |
| orderReady | output | 1 | Unit idle and able to accept an order |
| memRdBit | input | 1 | Serial operand digit from store |
| memRdEn | output | 1 | Operand digit consumed this cycle |
| memWrEn | output | 1 | Result digit written this cycle |
| memWrBit | output | 1 | Serial digit to store |
| memAddr | output | 10 | Operand address |
| memLong | output | 1 | Operand is long |
| done | output | 1 | Order completed (one-cycle pulse) |
| jumpReq | output | 1 | Conditional jump taken (one-cycle pulse) |
| jumpAddr | output | 10 | Jump target |
| halted | output | 1 | Unit stopped until reset |
| illegal | output | 1 | Unknown function code seen |
| accOut | output | 35 | Parallel view of accumulator |
| multOut | output | 35 | Parallel view of multiplier register |

## Verification
The assertions assume that memRdBit carries a valid digit in every cycle where memRdEn is high. They also assume that an order is taken only while orderReady is high. The bench sets memRdBit at the falling edge, and only in cycles where the unit requests a digit, taking the bits from a word it has chosen. It presents a new order only after the previous done. The single exception is the halted case, where it holds orderValid high on purpose to show that the order is ignored.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  localparam int FUNC_W = 5;

  typedef enum logic [FUNC_W-1:0] {
    FN_NOP  = 5'd0,
    FN_ADD  = 5'd1,
    FN_SUB  = 5'd2,
    FN_LDM  = 5'd3,
    FN_COL  = 5'd4,
    FN_STC  = 5'd5,
    FN_STO  = 5'd6,
    FN_SHR  = 5'd7,
    FN_SHL  = 5'd8,
    FN_JNEG = 5'd9,
    FN_JPOS = 5'd10,
    FN_STOP = 5'd11
  } func_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_HALT
  } state_e;

  // strobes from control to datapath, valid for one digit time
  typedef struct packed {
    logic first;     // first digit of the order
    logic lastDigit; // final digit of the order
    logic opValid;   // memRdBit holds a real operand digit
    logic accRot;    // rotate accumulator one place towards lsb
    logic useSum;    // rotate in the adder's sum digit
    logic clearIn;   // rotate in zero
    logic invOp;     // invert operand, carry-in one on first digit
    logic maskOp;    // AND operand with multiplier digit, rotate multiplier
    logic multLoad;  // shift operand digit into multiplier
    logic shr;       // arithmetic shift right by one
    logic shl;       // shift left by one
  } strobes_t;

endpackage

// File: rtl/sacc_dpath.sv
module sacc_dpath
  import sacc_pkg::*;
#(
  parameter int ACC_W = 35
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic             memRdBit,
  output logic             accLsb,
  output logic             memWrBit,
  output logic [ACC_W-1:0] accOut,
  output logic [ACC_W-1:0] multOut
);

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] multQ;
  logic             carryQ;
  logic             signQ;

  logic opRaw;
  logic opMasked;
  logic opBit;
  logic carryIn;
  logic sumBit;
  logic carryOut;
  logic rotIn;

  // operand digit, extended by the last digit seen once the word runs out
  assign opRaw    = strb.opValid ? memRdBit : signQ;
  assign opMasked = strb.maskOp ? (opRaw & multQ[0]) : opRaw;
  assign opBit    = opMasked ^ strb.invOp;
  assign carryIn  = strb.first ? strb.invOp : carryQ;
  assign sumBit   = accQ[0] ^ opBit ^ carryIn;
  assign carryOut = (accQ[0] & opBit) | (accQ[0] & carryIn) | (opBit & carryIn);

  always_comb begin
    if (strb.useSum)       rotIn = sumBit;
    else if (strb.clearIn) rotIn = 1'b0;
    else                   rotIn = accQ[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      multQ  <= '0;
      carryQ <= 1'b0;
      signQ  <= 1'b0;
    end else begin
      if (strb.opValid) signQ <= memRdBit;
      if (strb.useSum)  carryQ <= carryOut;

      if (strb.accRot)   accQ <= {rotIn, accQ[ACC_W-1:1]};
      else if (strb.shr) accQ <= {accQ[ACC_W-1], accQ[ACC_W-1:1]};
      else if (strb.shl) accQ <= {accQ[ACC_W-2:0], 1'b0};

      if (strb.multLoad)    multQ <= {opRaw, multQ[ACC_W-1:1]};
      else if (strb.maskOp) multQ <= {multQ[0], multQ[ACC_W-1:1]};
    end
  end

  assign accLsb   = accQ[0];
  assign memWrBit = accQ[0];
  assign accOut   = accQ;
  assign multOut  = multQ;

  // R4: the accumulator is zero once a store-and-clear finishes
  a_r4_clear_after_store: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearIn && strb.lastDigit) |=> (accQ == '0));

  // R3: multiplier register only moves under load or collate
  a_r3_mult_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.multLoad && !strb.maskOp) |=> $stable(multQ));

  // R7: at most one accumulator movement per digit
  a_r7_one_move: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.accRot, strb.shr, strb.shl}));

endmodule

// File: rtl/sacc_ctrl.sv
module sacc_ctrl
  import sacc_pkg::*;
#(
  parameter int ACC_W   = 35,
  parameter int SHORT_W = 17,
  parameter int ADDR_W  = 10,
  parameter int SHIFT_W = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  orderValid,
  input  logic [FUNC_W+ADDR_W+1:0] orderWord,
  input  logic                  accLsb,
  output logic                  orderReady,
  output strobes_t              strb,
  output logic                  memRdEn,
  output logic                  memWrEn,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memLong,
  output logic                  done,
  output logic                  jumpReq,
  output logic [ADDR_W-1:0]     jumpAddr,
  output logic                  halted,
  output logic                  illegal
);

  localparam int ORDER_W   = FUNC_W + ADDR_W + 2;
  localparam int SHIFT_MAX = (1 << SHIFT_W) - 1;
  localparam int MAX_LEN   = (ACC_W > SHIFT_MAX) ? ACC_W : SHIFT_MAX;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  // order fields; the bit between function and address is spare
  logic [FUNC_W-1:0] fnIn;
  logic [ADDR_W-1:0] addrIn;
  logic              longIn;
  assign fnIn   = orderWord[ORDER_W-1 -: FUNC_W];
  assign addrIn = orderWord[ADDR_W:1];
  assign longIn = orderWord[0];

  state_e            stateQ;
  logic [FUNC_W-1:0] fnQ;
  logic [ADDR_W-1:0] addrQ;
  logic              longQ;
  logic [CNT_W-1:0]  digitQ;

  logic [SHIFT_W-1:0] shiftCnt;
  logic [CNT_W-1:0]   execLen;
  logic [CNT_W-1:0]   opLen;
  logic               lastDigit;
  logic               isRead;
  logic               isStore;
  logic               isRotate;
  logic               isJump;
  logic               isShift;
  logic               fnLegal;

  assign shiftCnt = addrQ[SHIFT_W-1:0];
  assign opLen    = longQ ? CNT_W'(ACC_W) : CNT_W'(SHORT_W);
  assign fnLegal  = (fnIn <= FN_STOP);

  assign isRead   = (fnQ == FN_ADD) || (fnQ == FN_SUB) || (fnQ == FN_COL) || (fnQ == FN_LDM);
  assign isStore  = (fnQ == FN_STC) || (fnQ == FN_STO);
  assign isJump   = (fnQ == FN_JNEG) || (fnQ == FN_JPOS);
  assign isShift  = (fnQ == FN_SHR) || (fnQ == FN_SHL);
  assign isRotate = (fnQ == FN_ADD) || (fnQ == FN_SUB) || (fnQ == FN_COL) || isStore || isJump;

  always_comb begin
    execLen = CNT_W'(ACC_W);
    if (isShift) execLen = (shiftCnt == '0) ? CNT_W'(1) : CNT_W'(shiftCnt);
  end

  assign lastDigit = (digitQ == execLen - CNT_W'(1));

  // sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      fnQ     <= FN_NOP;
      addrQ   <= '0;
      longQ   <= 1'b0;
      digitQ  <= '0;
      done    <= 1'b0;
      jumpReq <= 1'b0;
      halted  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      jumpReq <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (orderValid) begin
            fnQ    <= fnIn;
            addrQ  <= addrIn;
            longQ  <= longIn;
            digitQ <= '0;
            if (!fnLegal) begin
              illegal <= 1'b1;
              halted  <= 1'b1;
              done    <= 1'b1;
              stateQ  <= ST_HALT;
            end else if (fnIn == FN_STOP) begin
              halted <= 1'b1;
              done   <= 1'b1;
              stateQ <= ST_HALT;
            end else if (fnIn == FN_NOP) begin
              done <= 1'b1;
            end else begin
              stateQ <= ST_EXEC;
            end
          end
        end
        ST_EXEC: begin
          digitQ <= digitQ + CNT_W'(1);
          if (lastDigit) begin
            stateQ <= ST_IDLE;
            digitQ <= '0;
            done   <= 1'b1;
            // the final digit leaving the accumulator is its sign
            if (isJump) jumpReq <= (fnQ == FN_JNEG) ? accLsb : !accLsb;
          end
        end
        default: stateQ <= ST_HALT;
      endcase
    end
  end

  // per-digit strobes
  always_comb begin
    strb = '0;
    if (stateQ == ST_EXEC) begin
      strb.first     = (digitQ == '0);
      strb.lastDigit = lastDigit;
      strb.opValid   = isRead && (digitQ < opLen);
      strb.accRot    = isRotate;
      strb.useSum    = (fnQ == FN_ADD) || (fnQ == FN_SUB) || (fnQ == FN_COL);
      strb.clearIn   = (fnQ == FN_STC);
      strb.invOp     = (fnQ == FN_SUB);
      strb.maskOp    = (fnQ == FN_COL);
      strb.multLoad  = (fnQ == FN_LDM);
      strb.shr       = (fnQ == FN_SHR) && (shiftCnt != '0);
      strb.shl       = (fnQ == FN_SHL) && (shiftCnt != '0);
    end
  end

  assign orderReady = (stateQ == ST_IDLE);
  assign memRdEn    = strb.opValid;
  assign memWrEn    = (stateQ == ST_EXEC) && isStore && (digitQ < opLen);
  assign memAddr    = addrQ;
  assign memLong    = longQ;
  assign jumpAddr   = addrQ;

  // R12: never read and write the store in the same digit
  a_r12_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  // R8: a jump request only accompanies completion
  a_r8_jump_with_done: assert property (@(posedge clk) disable iff (!rstN)
    jumpReq |-> done);

  // R10: halt is sticky and blocks new orders
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
  a_r10_halt_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !orderReady);

  // R11: an illegal order always leaves the unit halted
  a_r11_illegal_halts: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> halted);

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/serial_acc_unit.sv
module serial_acc_unit
  import sacc_pkg::*;
#(
  parameter int ACC_W   = 35,
  parameter int SHORT_W = 17,
  parameter int ADDR_W  = 10,
  parameter int SHIFT_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     orderValid,
  input  logic [FUNC_W+ADDR_W+1:0] orderWord,
  output logic                     orderReady,
  input  logic                     memRdBit,
  output logic                     memRdEn,
  output logic                     memWrEn,
  output logic                     memWrBit,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memLong,
  output logic                     done,
  output logic                     jumpReq,
  output logic [ADDR_W-1:0]        jumpAddr,
  output logic                     halted,
  output logic                     illegal,
  output logic [ACC_W-1:0]         accOut,
  output logic [ACC_W-1:0]         multOut
);

  strobes_t strb;
  logic     accLsb;

  sacc_ctrl #(
    .ACC_W  (ACC_W),
    .SHORT_W(SHORT_W),
    .ADDR_W (ADDR_W),
    .SHIFT_W(SHIFT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .orderValid(orderValid),
    .orderWord (orderWord),
    .accLsb    (accLsb),
    .orderReady(orderReady),
    .strb      (strb),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memLong   (memLong),
    .done      (done),
    .jumpReq   (jumpReq),
    .jumpAddr  (jumpAddr),
    .halted    (halted),
    .illegal   (illegal)
  );

  sacc_dpath #(
    .ACC_W(ACC_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .memRdBit(memRdBit),
    .accLsb  (accLsb),
    .memWrBit(memWrBit),
    .accOut  (accOut),
    .multOut (multOut)
  );

endmodule

// File: tb/serial_acc_unit_bench.sv
module serial_acc_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        orderValid = 1'b0;
  logic [16:0] orderWord = '0;
  logic        orderReady;
  logic        memRdBit = 1'b0;
  logic        memRdEn, memWrEn, memWrBit, memLong;
  logic [9:0]  memAddr, jumpAddr;
  logic        done, jumpReq, halted, illegal;
  logic [34:0] accOut, multOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [34:0] refAcc = '0;
  logic [34:0] refMult = '0;

  always #10 clk = ~clk;

  serial_acc_unit u_serial_acc_unit (
    .clk(clk), .rstN(rstN), .orderValid(orderValid), .orderWord(orderWord),
    .orderReady(orderReady), .memRdBit(memRdBit), .memRdEn(memRdEn),
    .memWrEn(memWrEn), .memWrBit(memWrBit), .memAddr(memAddr), .memLong(memLong),
    .done(done), .jumpReq(jumpReq), .jumpAddr(jumpAddr), .halted(halted),
    .illegal(illegal), .accOut(accOut), .multOut(multOut)
  );

  task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    orderValid = 1'b0;
    memRdBit   = 1'b0;
    rstN       = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    refAcc  = '0;
    refMult = '0;
    // R13 reset state
    chk("R13 acc", accOut, '0);
    chk("R13 mult", multOut, '0);
    chk("R13 ready/halted/illegal", 35'({orderReady, halted, illegal, done, jumpReq}), 35'b10000);
  endtask

  // one order through the serial port; the reference is updated at word level
  task automatic runOrder(input logic [4:0] fn, input logic [9:0] ad, input logic lg,
                          input logic [34:0] op, input logic spare);
    int cyc = 0;
    int rdCnt = 0;
    int wrCnt = 0;
    int opLen;
    int expCyc;
    int k;
    logic [34:0] wrVec = '0;
    logic [34:0] ext;
    logic [34:0] expWr;
    logic addrOk = 1'b1;
    logic expJump = 1'b0;
    logic isRd, isSt;
    opLen = lg ? 35 : 17;
    ext   = lg ? op : {{18{op[16]}}, op[16:0]};
    k     = int'(ad[5:0]);
    isRd  = (fn == 5'd1) || (fn == 5'd2) || (fn == 5'd3) || (fn == 5'd4);
    isSt  = (fn == 5'd5) || (fn == 5'd6);
    if (fn == 5'd0 || fn >= 5'd11) expCyc = 0;
    else if (fn == 5'd7 || fn == 5'd8) expCyc = (k == 0) ? 1 : k;
    else expCyc = 35;
    expWr = lg ? refAcc : {18'd0, refAcc[16:0]};

    @(negedge clk);
    chk("R12 ready before order", 35'(orderReady), 35'd1);
    orderValid = 1'b1;
    orderWord  = {fn, spare, ad, lg};
    @(negedge clk);
    orderValid = 1'b0;
    while (!done) begin
      if (memRdEn) begin
        memRdBit = op[rdCnt % 35];
        if (memAddr !== ad) addrOk = 1'b0;
        rdCnt++;
      end
      if (memWrEn) begin
        wrVec[wrCnt % 35] = memWrBit;
        if (memAddr !== ad) addrOk = 1'b0;
        wrCnt++;
      end
      cyc++;
      if (cyc > 200) break;
      @(negedge clk);
    end
    memRdBit = 1'b0;

    case (fn)
      5'd1: refAcc = refAcc + ext;
      5'd2: refAcc = refAcc - ext;
      5'd3: refMult = ext;
      5'd4: refAcc = refAcc + (ext & refMult);
      5'd5: refAcc = '0;
      5'd7: refAcc = 35'($signed(refAcc) >>> k);
      5'd8: refAcc = refAcc << k;
      5'd9: expJump = refAcc[34];
      5'd10: expJump = !refAcc[34];
      default: ;
    endcase

    chk("R12 digit cycles", 35'(cyc), 35'(expCyc));
    chk("R12 read digits", 35'(rdCnt), isRd ? 35'(opLen) : 35'd0);
    chk("R12 write digits", 35'(wrCnt), isSt ? 35'(opLen) : 35'd0);
    chk("R12 memAddr", 35'(addrOk), 35'd1);
    if (fn == 5'd1 || fn == 5'd2) chk("R2 add/sub acc", accOut, refAcc);
    else if (fn == 5'd4) chk("R6 collate acc", accOut, refAcc);
    else if (fn == 5'd5) chk("R4 clear acc", accOut, refAcc);
    else if (fn == 5'd6) chk("R5 store keeps acc", accOut, refAcc);
    else if (fn == 5'd7 || fn == 5'd8) chk("R7 shift acc", accOut, refAcc);
    else if (fn == 5'd9 || fn == 5'd10) chk("R8 jump keeps acc", accOut, refAcc);
    else if (fn == 5'd0) chk("R9 nop acc", accOut, refAcc);
    else chk("R1 acc", accOut, refAcc);
    chk("R3 mult", multOut, refMult);
    if (isSt) chk("R4 R5 stored word", wrVec, expWr);
    if (fn == 5'd9 || fn == 5'd10) begin
      chk("R8 jumpReq", 35'(jumpReq), 35'(expJump));
      if (expJump) chk("R8 jumpAddr", 35'(jumpAddr), 35'(ad));
    end else begin
      chk("R8 no jumpReq", 35'(jumpReq), 35'd0);
    end
  endtask

  function automatic logic [34:0] rnd35();
    return {3'($urandom), $urandom};
  endfunction

  initial begin
    doReset();

    // directed orders
    runOrder(5'd3, 10'd5, 1'b1, 35'h5_5555_5555, 1'b0);  // R3 load multiplier long
    runOrder(5'd1, 10'd6, 1'b1, 35'h0_0000_0007, 1'b0);  // R2 add long
    runOrder(5'd1, 10'd7, 1'b0, 35'h0_0001_FFFF, 1'b0);  // R2 short -1
    runOrder(5'd2, 10'd8, 1'b1, 35'h0_0000_0010, 1'b0);  // R2 subtract to negative
    runOrder(5'd9, 10'd300, 1'b0, '0, 1'b0);             // R8 negative taken
    runOrder(5'd10, 10'd301, 1'b0, '0, 1'b0);            // R8 not taken
    runOrder(5'd4, 10'd9, 1'b1, 35'h7_FFFF_FFFF, 1'b0);  // R6 collate
    runOrder(5'd6, 10'd10, 1'b1, '0, 1'b0);              // R5 store long
    runOrder(5'd6, 10'd10, 1'b0, '0, 1'b0);              // R5 store short
    runOrder(5'd7, 10'd0, 1'b0, '0, 1'b0);               // R7 count zero
    runOrder(5'd7, 10'd3, 1'b0, '0, 1'b0);               // R7 right 3
    runOrder(5'd7, 10'd40, 1'b0, '0, 1'b0);              // R7 right beyond width
    runOrder(5'd8, 10'd63, 1'b0, '0, 1'b0);              // R7 left max
    runOrder(5'd1, 10'd1, 1'b1, 35'h2_0000_0001, 1'b1);  // R1 spare bit ignored
    runOrder(5'd5, 10'd2, 1'b1, '0, 1'b0);               // R4 store and clear
    runOrder(5'd10, 10'd302, 1'b0, '0, 1'b0);            // R8 zero counts non-negative
    runOrder(5'd9, 10'd303, 1'b0, '0, 1'b0);             // R8 zero not negative
    runOrder(5'd0, 10'd4, 1'b1, '0, 1'b0);               // R9 nop

    // random mix of implemented orders
    for (int i = 0; i < 150; i++) begin
      logic [4:0] f;
      f = 5'($urandom_range(0, 10));
      runOrder(f, 10'($urandom), 1'($urandom), rnd35(), 1'($urandom));
    end

    // R10 stop, then orders ignored
    runOrder(5'd11, 10'd0, 1'b0, '0, 1'b0);
    chk("R10 halted", 35'(halted), 35'd1);
    @(negedge clk);
    orderValid = 1'b1;
    orderWord  = {5'd1, 1'b0, 10'd1, 1'b1};
    memRdBit   = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 not ready", 35'(orderReady), 35'd0);
    chk("R10 acc held", accOut, refAcc);
    chk("R10 mult held", multOut, refMult);
    chk("R10 no read", 35'(memRdEn), 35'd0);

    // R11 illegal code
    doReset();
    runOrder(5'd3, 10'd1, 1'b1, 35'h1_2345_6789, 1'b0);
    runOrder(5'd25, 10'd1, 1'b1, '0, 1'b0);
    chk("R11 illegal", 35'(illegal), 35'd1);
    chk("R11 halted", 35'(halted), 35'd1);
    chk("R11 mult held", multOut, refMult);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule